// File: doc/BRIEF.md
# Eight-Pin I/O Port with Interrupt-on-Change

This block is one general-purpose I/O port of eight pins placed behind a small synchronous register bus. Software selects the direction of each pin. It also sets an output latch, a per-pin pull-up request and a per-pin read inversion. The block drives the output value and output enable of every pin and samples the pin levels through a two-flop synchronizer. Eleven byte-wide registers are exposed on the bus.

Each input can be armed to raise an interrupt. A pin in change mode fires when its synchronized level differs from its level one clock earlier. A pin in compare mode fires while its level differs from a stored reference bit. The first event records one flag bit and freezes a snapshot of the whole port. No further flag or snapshot update happens until software clears the event by reading either the port or the snapshot, depending on a configuration bit. The interrupt output can be push-pull with either polarity, or open-drain.

For burst accesses, the bus can use an internal address pointer instead of the supplied address. The pointer advances after every access unless sequential operation is turned off in the configuration register.

Top module: `gpio_ioc_port`

## Requirements
- R1: After reset the direction register (0x00) reads 0xFF and the configuration (0x05) and output latch (0x0A) registers read 0x00. The interrupt output is idle, which after reset is push-pull active-low: irq_o=1, irq_oe=1.
- R2: A read of the port register (0x09) returns, per bit, (pin level XOR inversion bit 0x01) where the direction bit is 1, and the latch bit where the direction bit is 0. pin_oe is the inverse of the direction register and pin_out is the latch. pin_pu follows the pull-up register (0x06).
- R3: When the interrupt-control bit (0x04) is 0, an input pin with its enable bit (0x02) set raises the interrupt when its inverted synchronized level changes. A pin whose enable bit is 0 raises nothing.
- R4: When the interrupt-control bit is 1, an enabled input pin raises the interrupt while its level differs from its reference bit (0x03). The interrupt is raised again after a clear for as long as the mismatch persists.
- R5: The flag register (0x07) holds exactly one set bit, that of the lowest-numbered firing pin, even when several pins fire in the same cycle.
- R6: When the interrupt is raised, the capture register (0x08) takes the port value. While the event is pending, neither the flag nor the capture changes.
- R7: With configuration bit 0 = 0, a port read clears the pending event and a capture read does not.
- R8: With configuration bit 0 = 1, a capture read clears the pending event and a port read does not.
- R9: With configuration bit 2 = 0 the output is push-pull: irq_oe=1, and irq_o equals pending when bit 1 = 1 and equals not-pending when bit 1 = 0. With bit 2 = 1, irq_o=0 and irq_oe equals pending.
- R10: With bus_seq=1 the access uses the internal pointer. After each access the pointer moves to the next register, wrapping from 0x0A to 0x00. When configuration bit 5 is 1, the pointer stays on the register just accessed.
- R11: Writes to the flag and capture addresses change nothing. Reads of addresses above 0x0A return 0x00. A write to the port address loads the output latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_addr | input | 4 | Register address, used when bus_seq is 0 |
| bus_seq | input | 1 | Take the address from the internal pointer |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rd | input | 1 | Read strobe; data valid the cycle after |
| bus_rdata | output | 8 | Read data, held between reads |
| pin_in | input | 8 | Raw pin levels |
| pin_out | output | 8 | Output value per pin |
| pin_oe | output | 8 | Output enable per pin |
| pin_pu | output | 8 | Pull-up request per pin |
| irq_o | output | 1 | Interrupt output level |
| irq_oe | output | 1 | Interrupt output drive enable |

## Verification
The port read path is driven from a table of direction, inversion, latch and pin patterns: all inputs, all inputs inverted, all outputs, split nibbles in both orientations, and alternating bits. Together these separate the direction mux from the inversion path on each half of the port. The interrupt logic is exercised three ways. A change on a disarmed pin shows that the enable is honoured. Two pins firing together show the one-hot flag and its priority. A later change while the event is pending shows that the flag and capture are frozen. Compare mode is tried with a persisting mismatch, which must re-raise after a clear, and with a matched reference, which must not.

// File: rtl/gpx_pkg.sv
// Package: register addresses and configuration bit positions shared by the
// I/O port blocks. Assumes byte-wide registers and a 4-bit address.
package gpx_pkg;
    localparam int ADR_W = 4;
    typedef logic [ADR_W-1:0] adr_t;

    localparam adr_t A_DIR   = 4'h0;
    localparam adr_t A_INV   = 4'h1;
    localparam adr_t A_IEN   = 4'h2;
    localparam adr_t A_REF   = 4'h3;
    localparam adr_t A_MODE  = 4'h4;
    localparam adr_t A_CFG   = 4'h5;
    localparam adr_t A_PUP   = 4'h6;
    localparam adr_t A_FLAG  = 4'h7;
    localparam adr_t A_CAP   = 4'h8;
    localparam adr_t A_PORT  = 4'h9;
    localparam adr_t A_LATCH = 4'hA;
    localparam adr_t A_LAST  = A_LATCH;

    localparam int CB_MIRROR  = 6;
    localparam int CB_SEQ_OFF = 5;
    localparam int CB_HWADR   = 3;
    localparam int CB_ODRAIN  = 2;
    localparam int CB_ACT_HI  = 1;
    localparam int CB_CLR_CAP = 0;
endpackage

// File: rtl/gpx_sync.sv
// Two-flop synchronizer for the raw pin levels.
// Assumes pins are asynchronous to clk; reset value is all zero.
module gpx_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;

    // purpose: shift raw levels through two stages
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            q      <= '0;
        end else begin
            meta_q <= d;
            q      <= meta_q;
        end
    end
endmodule

// File: rtl/gpx_regfile.sv
// Register file: writable control registers, burst address pointer, read
// mux with registered read data, and the clear request for the interrupt.
// Assumes a write and a read in one cycle count as a single access.
module gpx_regfile
    import gpx_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  adr_t          bus_addr,
    input  logic          bus_seq,
    input  logic          bus_wr,
    input  logic [DW-1:0] bus_wdata,
    input  logic          bus_rd,
    output logic [DW-1:0] bus_rdata,
    input  logic [DW-1:0] flag_i,
    input  logic [DW-1:0] cap_i,
    input  logic [DW-1:0] port_i,
    output logic [DW-1:0] dir_q,
    output logic [DW-1:0] inv_q,
    output logic [DW-1:0] ien_q,
    output logic [DW-1:0] ref_q,
    output logic [DW-1:0] mode_q,
    output logic [DW-1:0] cfg_q,
    output logic [DW-1:0] pup_q,
    output logic [DW-1:0] latch_q,
    output logic          clr_req
);
    adr_t          ptr_q;
    adr_t          eff;
    adr_t          ptr_nx;
    logic [DW-1:0] rd_mux;
    logic          access;

    // purpose: choose the supplied or the pointer address
    always_comb begin
        eff    = bus_seq ? ptr_q : bus_addr;
        access = bus_wr | bus_rd;
    end

    // purpose: next pointer value after an access
    always_comb begin
        if (eff > A_LAST)                ptr_nx = '0;
        else if (cfg_q[CB_SEQ_OFF])      ptr_nx = eff;
        else if (eff == A_LAST)          ptr_nx = '0;
        else                             ptr_nx = eff + adr_t'(1);
    end

    // purpose: update the control registers on writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q   <= '1;
            inv_q   <= '0;
            ien_q   <= '0;
            ref_q   <= '0;
            mode_q  <= '0;
            cfg_q   <= '0;
            pup_q   <= '0;
            latch_q <= '0;
        end else if (bus_wr) begin
            case (eff)
                A_DIR:   dir_q   <= bus_wdata;
                A_INV:   inv_q   <= bus_wdata;
                A_IEN:   ien_q   <= bus_wdata;
                A_REF:   ref_q   <= bus_wdata;
                A_MODE:  mode_q  <= bus_wdata;
                A_CFG:   cfg_q   <= bus_wdata;
                A_PUP:   pup_q   <= bus_wdata;
                A_PORT,
                A_LATCH: latch_q <= bus_wdata;
                default: ;
            endcase
        end
    end

    // purpose: advance the burst pointer after every access
    always_ff @(posedge clk) begin
        if (!rst_n)       ptr_q <= '0;
        else if (access)  ptr_q <= ptr_nx;
    end

    // purpose: select the register to read
    always_comb begin
        case (eff)
            A_DIR:   rd_mux = dir_q;
            A_INV:   rd_mux = inv_q;
            A_IEN:   rd_mux = ien_q;
            A_REF:   rd_mux = ref_q;
            A_MODE:  rd_mux = mode_q;
            A_CFG:   rd_mux = cfg_q;
            A_PUP:   rd_mux = pup_q;
            A_FLAG:  rd_mux = flag_i;
            A_CAP:   rd_mux = cap_i;
            A_PORT:  rd_mux = port_i;
            A_LATCH: rd_mux = latch_q;
            default: rd_mux = '0;
        endcase
    end

    // purpose: register read data and hold it between reads
    always_ff @(posedge clk) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rd_mux;
    end

    // purpose: decide whether this read clears the pending event
    always_comb begin
        clr_req = bus_rd & (cfg_q[CB_CLR_CAP] ? (eff == A_CAP) : (eff == A_PORT));
    end

    p_rst_dir_r1: assert property (@(posedge clk) !rst_n |=> dir_q == '1);
    p_ptr_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_q <= A_LAST);
    p_seq_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (access && cfg_q[CB_SEQ_OFF] && eff <= A_LAST) |=> ptr_q == $past(eff));
endmodule

// File: rtl/gpx_irq.sv
// Interrupt-on-change engine: per-pin event detect in change or compare
// mode, one-hot flag of the lowest firing pin, port snapshot, clear, and
// the output driver. Assumes pin levels are already synchronized.
module gpx_irq
    import gpx_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] lvl_i,
    input  logic [DW-1:0] inv_i,
    input  logic [DW-1:0] dir_i,
    input  logic [DW-1:0] ien_i,
    input  logic [DW-1:0] mode_i,
    input  logic [DW-1:0] ref_i,
    input  logic [DW-1:0] port_i,
    input  logic          clr_req,
    input  logic          odrain_i,
    input  logic          act_hi_i,
    output logic [DW-1:0] flag_q,
    output logic [DW-1:0] cap_q,
    output logic          irq_o,
    output logic          irq_oe
);
    logic [DW-1:0] val;
    logic [DW-1:0] prev_q;
    logic [DW-1:0] hit;
    logic [DW-1:0] first;
    logic          pend;

    // purpose: inverted level used by both compare modes
    always_comb val = lvl_i ^ inv_i;

    // purpose: remember last cycle's value for change detection
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= val;
    end

    // purpose: per-pin event condition
    for (genvar i = 0; i < DW; i++) begin : g_pin
        always_comb begin
            hit[i] = ien_i[i] & dir_i[i] &
                     (mode_i[i] ? (val[i] ^ ref_i[i]) : (val[i] ^ prev_q[i]));
        end
    end

    // purpose: isolate the lowest-numbered firing pin
    always_comb begin
        first = hit & (~hit + DW'(1));
        pend  = |flag_q;
    end

    // purpose: set, hold and clear the flag and snapshot
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= '0;
            cap_q  <= '0;
        end else if (clr_req) begin
            flag_q <= '0;
        end else if (!pend && |hit) begin
            flag_q <= first;
            cap_q  <= port_i;
        end
    end

    // purpose: drive the interrupt line in the configured style
    always_comb begin
        if (odrain_i) begin
            irq_o  = 1'b0;
            irq_oe = pend;
        end else begin
            irq_o  = act_hi_i ? pend : ~pend;
            irq_oe = 1'b1;
        end
    end

    p_flag_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(flag_q));
    p_flag_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && !clr_req) |=> flag_q == $past(flag_q));
    p_cap_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        pend |=> $stable(cap_q));
    p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        clr_req |=> flag_q == '0);
    p_pushpull_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !odrain_i |-> irq_oe);
endmodule

// File: rtl/gpio_ioc_port.sv
// Top: one I/O port with register bus and interrupt-on-change.
// Assumes DW >= 7 so every configuration bit exists.
module gpio_ioc_port
    import gpx_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ADR_W-1:0] bus_addr,
    input  logic             bus_seq,
    input  logic             bus_wr,
    input  logic [DW-1:0]    bus_wdata,
    input  logic             bus_rd,
    output logic [DW-1:0]    bus_rdata,
    input  logic [DW-1:0]    pin_in,
    output logic [DW-1:0]    pin_out,
    output logic [DW-1:0]    pin_oe,
    output logic [DW-1:0]    pin_pu,
    output logic             irq_o,
    output logic             irq_oe
);
    logic [DW-1:0] lvl;
    logic [DW-1:0] dir_q, inv_q, ien_q, ref_q, mode_q, cfg_q, pup_q, latch_q;
    logic [DW-1:0] flag_q, cap_q, port_val;
    logic          clr_req;

    gpx_sync #(.W(DW)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(pin_in), .q(lvl)
    );

    // purpose: port value seen by software and by the snapshot
    always_comb port_val = (dir_q & (lvl ^ inv_q)) | (~dir_q & latch_q);

    gpx_regfile #(.DW(DW)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_seq(bus_seq),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rd(bus_rd),
        .bus_rdata(bus_rdata), .flag_i(flag_q), .cap_i(cap_q),
        .port_i(port_val), .dir_q(dir_q), .inv_q(inv_q), .ien_q(ien_q),
        .ref_q(ref_q), .mode_q(mode_q), .cfg_q(cfg_q), .pup_q(pup_q),
        .latch_q(latch_q), .clr_req(clr_req)
    );

    gpx_irq #(.DW(DW)) u_irq (
        .clk(clk), .rst_n(rst_n), .lvl_i(lvl), .inv_i(inv_q), .dir_i(dir_q),
        .ien_i(ien_q), .mode_i(mode_q), .ref_i(ref_q), .port_i(port_val),
        .clr_req(clr_req), .odrain_i(cfg_q[CB_ODRAIN]),
        .act_hi_i(cfg_q[CB_ACT_HI]), .flag_q(flag_q), .cap_q(cap_q),
        .irq_o(irq_o), .irq_oe(irq_oe)
    );

    // purpose: pin drive outputs
    always_comb begin
        pin_out = latch_q;
        pin_oe  = ~dir_q;
        pin_pu  = pup_q;
    end

    p_oe_dir_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_oe & dir_q) == '0);
endmodule

// File: tb/test_gpio_ioc_port.sv
module test_gpio_ioc_port;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] bus_addr = '0;
    logic       bus_seq = 1'b0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_rdata;
    logic [7:0] pin_in = '0;
    logic [7:0] pin_out, pin_oe, pin_pu;
    logic       irq_o, irq_oe;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #10 clk = ~clk;

    gpio_ioc_port i_gpio_ioc_port (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_seq(bus_seq),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rd(bus_rd),
        .bus_rdata(bus_rdata), .pin_in(pin_in), .pin_out(pin_out),
        .pin_oe(pin_oe), .pin_pu(pin_pu), .irq_o(irq_o), .irq_oe(irq_oe)
    );

    // {dir, inv, latch, pins, expected port read}
    localparam logic [39:0] VEC [6] = '{
        {8'hFF, 8'h00, 8'h00, 8'hA5, 8'hA5},
        {8'hFF, 8'hFF, 8'h00, 8'hA5, 8'h5A},
        {8'h00, 8'h00, 8'h3C, 8'hFF, 8'h3C},
        {8'hF0, 8'h0F, 8'h0C, 8'h5A, 8'h5C},
        {8'h0F, 8'h0F, 8'h81, 8'h33, 8'h8C},
        {8'hAA, 8'h00, 8'h55, 8'h00, 8'h55}
    };

    task automatic chk(input string what, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", what, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1; bus_seq = 1'b0;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, input bit seq, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1; bus_seq = seq;
        @(negedge clk);
        bus_rd = 1'b0; bus_seq = 1'b0;
        d = bus_rdata;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [7:0] v, c;
        do_reset();

        // R1 reset values and idle interrupt
        rd(4'h0, 0, v); chk("R1 dir reset", v, 8'hFF);
        rd(4'h5, 0, v); chk("R1 cfg reset", v, 8'h00);
        rd(4'hA, 0, v); chk("R1 latch reset", v, 8'h00);
        chk("R1 irq_o idle", {7'd0, irq_o}, 8'h01);
        chk("R1 irq_oe idle", {7'd0, irq_oe}, 8'h01);

        // R2 table of port read patterns
        for (int k = 0; k < 6; k++) begin
            wr(4'h0, VEC[k][39:32]);
            wr(4'h1, VEC[k][31:24]);
            wr(4'hA, VEC[k][23:16]);
            pin_in = VEC[k][15:8];
            settle();
            chk($sformatf("R2 row %0d pin_oe", k), pin_oe, ~VEC[k][39:32]);
            chk($sformatf("R2 row %0d pin_out", k), pin_out, VEC[k][23:16]);
            rd(4'h9, 0, v);
            chk($sformatf("R2 row %0d port", k), v, VEC[k][7:0]);
        end
        wr(4'h6, 8'h5A);
        chk("R2 pull-up", pin_pu, 8'h5A);
        wr(4'h9, 8'h77);
        rd(4'hA, 0, v); chk("R11 port write loads latch", v, 8'h77);

        // R3 change mode
        pin_in = 8'h00;
        do_reset();
        wr(4'h2, 8'h81);
        pin_in = 8'h10; settle();
        chk("R3 disarmed pin no irq", {7'd0, irq_o}, 8'h01);
        pin_in = 8'h91; settle();
        chk("R3 change raises irq", {7'd0, irq_o}, 8'h00);
        rd(4'h7, 0, v); chk("R5 lowest pin flag", v, 8'h01);
        rd(4'h8, 0, v); chk("R6 capture", v, 8'h91);
        pin_in = 8'h90; settle();
        rd(4'h7, 0, v); chk("R6 flag frozen", v, 8'h01);
        rd(4'h8, 0, v); chk("R6 capture frozen", v, 8'h91);
        chk("R7 capture read keeps irq", {7'd0, irq_o}, 8'h00);
        rd(4'h9, 0, v); chk("R7 port value", v, 8'h90);
        chk("R7 port read clears", {7'd0, irq_o}, 8'h01);
        rd(4'h7, 0, v); chk("R7 flag cleared", v, 8'h00);

        // R8 capture read clears
        wr(4'h5, 8'h01);
        pin_in = 8'h10; settle();
        rd(4'h9, 0, v);
        chk("R8 port read keeps irq", {7'd0, irq_o}, 8'h00);
        rd(4'h8, 0, v); chk("R8 capture value", v, 8'h10);
        chk("R8 capture read clears", {7'd0, irq_o}, 8'h01);

        // R4 compare mode
        wr(4'h5, 8'h00);
        wr(4'h2, 8'h02);
        wr(4'h4, 8'h02);
        wr(4'h3, 8'h00);
        pin_in = 8'h12; settle();
        rd(4'h7, 0, v); chk("R4 compare flag", v, 8'h02);
        rd(4'h9, 0, v);
        repeat (2) @(negedge clk);
        chk("R4 mismatch re-raises", {7'd0, irq_o}, 8'h00);
        wr(4'h3, 8'h02);
        rd(4'h9, 0, v);
        repeat (3) @(negedge clk);
        chk("R4 matched stays clear", {7'd0, irq_o}, 8'h01);

        // R9 output styles
        wr(4'h5, 8'h02);
        chk("R9 active-high idle", {6'd0, irq_oe, irq_o}, 8'h02);
        wr(4'h3, 8'h00); settle();
        chk("R9 active-high pending", {6'd0, irq_oe, irq_o}, 8'h03);
        wr(4'h5, 8'h06);
        chk("R9 open-drain pending", {6'd0, irq_oe, irq_o}, 8'h02);
        wr(4'h3, 8'h02);
        rd(4'h9, 0, v);
        repeat (2) @(negedge clk);
        chk("R9 open-drain released", {6'd0, irq_oe, irq_o}, 8'h00);

        // R10 burst pointer
        wr(4'h5, 8'h00);
        wr(4'h0, 8'hFE);
        wr(4'h1, 8'h11);
        rd(4'hA, 0, v);
        rd(4'h0, 1, v); chk("R10 wrap to 0x00", v, 8'hFE);
        rd(4'h0, 1, v); chk("R10 advance to 0x01", v, 8'h11);
        wr(4'h5, 8'h20);
        rd(4'h3, 0, v);
        rd(4'h0, 1, v); chk("R10 pointer held first", v, 8'h02);
        rd(4'h0, 1, v); chk("R10 pointer held second", v, 8'h02);

        // R11 read-only and unmapped addresses
        wr(4'h5, 8'h00);
        rd(4'h8, 0, c);
        wr(4'h7, 8'hFF);
        wr(4'h8, 8'hFF);
        rd(4'h7, 0, v); chk("R11 flag write ignored", v, 8'h00);
        rd(4'h8, 0, v); chk("R11 capture write ignored", v, c);
        chk("R11 no irq from writes", {7'd0, irq_o}, 8'h01);
        rd(4'hC, 0, v); chk("R11 unmapped reads zero", v, 8'h00);

        finish_run();
    end
endmodule